// File: doc/BRIEF.md
# Oversampled Audio Output Serializer

This block takes one left and one right 24-bit two's-complement sample per word period and shifts them out MSB first on two serial data lines. It also produces the bit clock and the word clock that a downstream audio DAC needs. All timing comes from a single core clock `clk`, which runs at twice the system clock. The system-clock-to-sample-rate ratio is supplied as a configuration input. An oversampling select chooses between eight and four word periods per input sample.

Once per word period the block raises `sample_req` for one cycle and captures both channel samples together with the configuration at the end of that cycle. Each word is right-justified inside its slot at 16, 18, 20 or 24 bits. Any slot bits before the MSB repeat the sign bit. After reset the outputs hold a fixed idle state for a parameterised initialization window before the first request is made.

Top module: `os_audio_serializer`

## Requirements
- R1: While `rst_n` is low, and for `INIT_CLKS` (default 2048, i.e. 1024 system clocks) `clk` edges after it rises, `bck`, `dat_l` and `dat_r` are 0, `wck` is 1 and `sample_req` is 0.
- R2: `sample_req` first goes high in the cycle after the `INIT_CLKS`-th edge following reset release. It is never high for two consecutive cycles.
- R3: `ratio_sel` encodes the system-clock ratio as 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, and 6 or 7 act as 256. One word period lasts 2*ratio/OSR `clk` cycles, where OSR is 4 or 8. `sample_req` repeats exactly once per word period, in the last cycle of the word.
- R4: A word slot holds 24 bit-clock periods for ratios 192, 384 and 768, and 32 bit-clock periods otherwise. `bck` is low for the first half and high for the second half of each bit period.
- R5: OSR is 4 when `x4_mode` is 1, and also when `ratio_sel` is 0 or 1 whatever `x4_mode` is; otherwise OSR is 8.
- R6: `wck` is 1 during the first half of the bit slots of a word and 0 during the second half.
- R7: Data is MSB first and right-justified: the LSB occupies the last bit slot of the word, and every slot before the MSB carries the sample's bit 23 (sign).
- R8: `wlen_sel` selects the word length as 00=16, 01=18, 10=20, 11=24 bits. A shorter word is bits 23 down to 24-W of the sample (the low bits are dropped).
- R9: Once streaming, `dat_l`, `dat_r` and `wck` change only on a cycle in which `bck` falls.
- R10: `ratio_sel`, `x4_mode` and `wlen_sel` are captured only in a `sample_req` cycle. A change at any other time has no effect on the word in progress.
- R11: `left_in` and `right_in` are captured only in a `sample_req` cycle. Later changes do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | System-clock ratio code |
| x4_mode | input | 1 | Select four-times oversampling |
| wlen_sel | input | 2 | Output word length code |
| left_in | input | DW | Left sample, two's complement |
| right_in | input | DW | Right sample, two's complement |
| sample_req | output | 1 | One-cycle load strobe per word period |
| bck | output | 1 | Output bit clock |
| wck | output | 1 | Output word clock |
| dat_l | output | 1 | Left serial data |
| dat_r | output | 1 | Right serial data |

## Verification
Two things can fall in the same cycle: the load strobe, and a configuration or sample change on the inputs. The bench presents every new ratio, oversampling mode, word length and sample pair exactly in the `sample_req` cycle. It then expects the word that starts on the next edge to follow that new setting in full. Later in the same word it scrambles all inputs at a random tick, and judges that the remaining bits, bit-clock phases and the next strobe still follow the values captured at the strobe.

// File: rtl/os_audio_serializer.sv
module os_audio_serializer #(
  parameter int DW        = 24,
  parameter int INIT_CLKS = 2048,
  parameter int TW        = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ratio_sel,
  input  logic          x4_mode,
  input  logic [1:0]    wlen_sel,
  input  logic [DW-1:0] left_in,
  input  logic [DW-1:0] right_in,
  output logic          sample_req,
  output logic          bck,
  output logic          wck,
  output logic          dat_l,
  output logic          dat_r
);
  localparam int IW = $clog2(INIT_CLKS + 1);

  logic [IW-1:0] init_cnt;
  logic          init_done, fresh, running;
  logic [TW-1:0] tcnt, last, slot;
  logic [1:0]    hs_d, hs_q;
  logic          b24_d, b24_q, osr4;
  logic [4:0]    wl_d, wl_q;
  logic [DW-1:0] smp_l, smp_r;
  logic [5:0]    bits, idx;
  logic [2:0]    shamt;

  always_comb begin
    osr4  = x4_mode || (ratio_sel < 3'd2);
    b24_d = (ratio_sel == 3'd1) || (ratio_sel == 3'd3) || (ratio_sel == 3'd5);
    case (ratio_sel)
      3'd0:    hs_d = 2'd0;
      3'd1:    hs_d = 2'd1;
      3'd2:    hs_d = osr4 ? 2'd1 : 2'd0;
      3'd3:    hs_d = osr4 ? 2'd2 : 2'd1;
      3'd4:    hs_d = osr4 ? 2'd2 : 2'd1;
      3'd5:    hs_d = osr4 ? 2'd3 : 2'd2;
      default: hs_d = osr4 ? 2'd1 : 2'd0;
    endcase
    case (wlen_sel)
      2'b00:   wl_d = 5'd16;
      2'b01:   wl_d = 5'd18;
      2'b10:   wl_d = 5'd20;
      default: wl_d = 5'd24;
    endcase
  end

  assign init_done  = (init_cnt == IW'(INIT_CLKS));
  assign bits       = b24_q ? 6'd24 : 6'd32;
  assign shamt      = {1'b0, hs_q} + 3'd1;
  assign last       = (TW'(bits) << shamt) - TW'(1);
  assign slot       = tcnt >> shamt;
  assign idx        = bits - 6'd1 - slot[5:0];
  assign sample_req = init_done && (fresh || tcnt == last);

  function automatic logic pick(input logic [DW-1:0] s, input logic [5:0] i, input logic [4:0] w);
    if (i >= {1'b0, w}) return s[DW-1];
    return s[DW - int'(w) + int'(i)];
  endfunction

  assign bck   = running && tcnt[hs_q];
  assign wck   = !running || (slot < TW'(bits >> 1));
  assign dat_l = running && pick(smp_l, idx, wl_q);
  assign dat_r = running && pick(smp_r, idx, wl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      fresh    <= 1'b1;
      running  <= 1'b0;
      tcnt     <= '0;
      hs_q     <= 2'd0;
      b24_q    <= 1'b0;
      wl_q     <= 5'd16;
      smp_l    <= '0;
      smp_r    <= '0;
    end else begin
      if (!init_done) init_cnt <= init_cnt + IW'(1);
      if (sample_req) begin
        tcnt    <= '0;
        fresh   <= 1'b0;
        running <= 1'b1;
        hs_q    <= hs_d;
        b24_q   <= b24_d;
        wl_q    <= wl_d;
        smp_l   <= left_in;
        smp_r   <= right_in;
      end else if (running) begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  p_quiet_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !sample_req);
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!bck && wck && !dat_l && !dat_r));
  p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |=> !sample_req);
  p_req_high_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_req && running) |-> bck);
  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (tcnt <= last));
  p_change_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (!$stable(dat_l) || !$stable(dat_r) || !$stable(wck)))
      |-> $fell(bck));
endmodule

// File: tb/os_audio_serializer_bench.sv
module os_audio_serializer_bench;
  localparam int INIT = 2048;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] ratio_sel;
  logic x4_mode;
  logic [1:0] wlen_sel;
  logic [23:0] left_in, right_in;
  logic sample_req, bck, wck, dat_l, dat_r;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  os_audio_serializer u_os_audio_serializer (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .x4_mode(x4_mode),
    .wlen_sel(wlen_sel), .left_in(left_in), .right_in(right_in),
    .sample_req(sample_req), .bck(bck), .wck(wck), .dat_l(dat_l), .dat_r(dat_r));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic int ratio_of(input int sel);
    case (sel)
      0: return 128; 1: return 192; 3: return 384; 4: return 512; 5: return 768;
      default: return 256;
    endcase
  endfunction

  function automatic int wlen_of(input int code);
    case (code) 0: return 16; 1: return 18; 2: return 20; default: return 24; endcase
  endfunction

  function automatic bit exp_bit(input logic [23:0] s, input int b, input int nb, input int w);
    int lead = nb - w;
    if (b < lead) return s[23];
    return s[23 - (b - lead)];
  endfunction

  task automatic check_idle(input string tag);
    chk(!bck && wck && !dat_l && !dat_r, tag, {bck, wck, dat_l, dat_r}, 4'b0100);
    chk(!sample_req, tag, sample_req, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    for (int n = 1; n <= INIT; n++) begin
      @(negedge clk);
      if (n < INIT) begin
        if (n % 256 == 1 || n == INIT - 1) check_idle("R1 init window");
        else chk(!sample_req, "R1 no request", sample_req, 0);
      end else begin
        chk(sample_req, "R2 first request", sample_req, 1);
      end
    end
  endtask

  task automatic run_word(input int sel, input bit x4, input int wc,
                          input logic [23:0] l, input logic [23:0] r,
                          input string tag, input bit first);
    int ratio, osr, per, nb, h, w, pk, b;
    bit pb, pl, pr, pw;
    ratio_sel = 3'(sel); x4_mode = x4; wlen_sel = 2'(wc);
    left_in = l; right_in = r;
    ratio = ratio_of(sel);
    osr = (x4 || sel < 2) ? 4 : 8;
    per = 2 * ratio / osr;
    nb = (ratio % 3 == 0) ? 24 : 32;
    h = per / (2 * nb);
    w = wlen_of(wc);
    pk = $urandom_range(per - 2, 0);
    pb = bck; pl = dat_l; pr = dat_r; pw = wck;
    for (int k = 0; k < per; k++) begin
      @(negedge clk);
      b = k / (2 * h);
      chk(bck == ((k / h) % 2), {"R4 ", tag}, bck, (k / h) % 2);
      chk(wck == (b < nb / 2), {"R6 ", tag}, wck, b < nb / 2);
      chk(dat_l == exp_bit(l, b, nb, w), {"R7 R8 left ", tag}, dat_l, exp_bit(l, b, nb, w));
      chk(dat_r == exp_bit(r, b, nb, w), {"R7 R8 right ", tag}, dat_r, exp_bit(r, b, nb, w));
      if (k == per - 1) chk(sample_req, {"R3 period ", tag}, sample_req, 1);
      else chk(!sample_req, {"R2 R3 early request ", tag}, sample_req, 0);
      if (!(first && k == 0) && (dat_l != pl || dat_r != pr || wck != pw))
        chk(pb && !bck, {"R9 ", tag}, {pb, bck}, 2);
      pb = bck; pl = dat_l; pr = dat_r; pw = wck;
      if (k == pk) begin
        ratio_sel = 3'($urandom_range(7, 0)); x4_mode = 1'($urandom_range(1, 0));
        wlen_sel = 2'($urandom_range(3, 0));
        left_in = 24'($urandom); right_in = 24'($urandom);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; ratio_sel = 3'd2; x4_mode = 1'b0; wlen_sel = 2'd0;
    left_in = '0; right_in = '0;
    do_reset();
    run_word(2, 0, 3, 24'h800001, 24'h7FFFFF, "R3 8x ratio256", 1);
    run_word(5, 1, 0, 24'hFF8012, 24'h00FFFF, "R8 16-bit truncation", 0);
    run_word(0, 0, 1, 24'hA5A5A5, 24'h5A5A5A, "R5 ratio128 forced 4x", 0);
    run_word(1, 0, 2, 24'h123456, 24'hFEDCBA, "R5 ratio192 forced 4x", 0);
    run_word(7, 0, 3, 24'h400000, 24'hC00000, "R5 code7 as 256", 0);
    run_word(3, 0, 1, 24'h000001, 24'hFFFFFE, "R10 R11 held config", 0);
    run_word(4, 1, 2, 24'h7F0F0F, 24'h80F0F0, "R3 ratio512 4x", 0);
    for (int i = 0; i < 60; i++)
      run_word($urandom_range(7, 0), 1'($urandom_range(1, 0)), $urandom_range(3, 0),
               24'($urandom), 24'($urandom), "R10 R11 random", 0);
    do_reset();
    run_word(5, 0, 3, 24'h876543, 24'h0ABCDE, "R1 R2 after second reset", 1);
    summary();
  end
endmodule